// File: doc/BRIEF.md
# Two-Level Interrupt Steering Controller

This block collects up to 32 peripheral request lines and turns them into two CPU-facing interrupt requests. The first is a low-priority normal request, wired to CPU interrupt input 2. The second is a high-priority fast request, wired to CPU interrupt input 3.

Each source is captured on a rising edge of its line and held in a pending latch. Software acknowledges a pending source by writing a one to its bit in the end-of-interrupt register.

Software talks to the block through a single-cycle register port:

- Enables change only through a pair of registers. One sets enable bits and the other clears them, so no read-modify-write is needed.
- A per-source select register steers each enabled pending source to the normal output or to the fast output.
- Software can read four things back: the raw pending vector, the enabled pending sources per output, the select bits and the enable mask.

Register offsets are in bytes, and the access width is one word. Bit n of every data word always refers to source n.

| Offset | Register | Access |
|---|---|---|
| 0x00 | raw pending | read-only |
| 0x04 | normal status | read-only |
| 0x08 | fast status | read-only |
| 0x0C | select | read/write |
| 0x10 | enable mask | read-only |
| 0x14 | enable set | write-only |
| 0x18 | enable clear | write-only |
| 0x1C | end-of-interrupt | write-only |

Top module: `irq_steer_ctrl`

## Requirements
- R1: A source becomes pending in the cycle after its input is sampled high when it was sampled low the cycle before. A line that stays high does not re-latch after an acknowledge.
- R2: A write to offset 0x14 sets the enable bit of every source whose data bit is 1. Bits written as 0 leave their enables unchanged.
- R3: A write to offset 0x18 clears the enable bit of every source whose data bit is 1. Writing all ones disables every source.
- R4: Offset 0x0C is the read/write select register. A bit value of 1 steers that source to the fast output, and 0 steers it to the normal output.
- R5: A read of offset 0x04 returns pending AND enabled AND NOT select.
- R6: A read of offset 0x08 returns pending AND enabled AND select.
- R7: A read of offset 0x00 returns the pending vector, regardless of enable or select.
- R8: A read of offset 0x10 returns the enable mask. The write-only offsets (0x14, 0x18, 0x1C) read as zero. Writes to offsets 0x00, 0x04, 0x08 and 0x10 change nothing.
- R9: A write to offset 0x1C clears the pending bit of every source whose data bit is 1. If a rising edge on a source coincides with its acknowledge, the source stays pending.
- R10: Both outputs are registered and active high. Each output is the OR of its status vector, taken one cycle earlier.
- R11: Reset clears the pending latches, the enable mask, the select bits and both outputs.
- R12: An access whose address bits [1:0] are not zero writes nothing, and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Peripheral request lines, edge-captured |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | NUM_SRC | Write data, one bit per source |
| bus_rdata_o | output | NUM_SRC | Read data, combinational, zero when no read is active |
| irq_norm_o | output | 1 | Low-priority normal request (CPU input 2) |
| irq_fast_o | output | 1 | High-priority fast request (CPU input 3) |

## Verification
Single-source pulses are tried with the select bit at 0 and then at 1. This separates the normal path from the fast path, and shows whether status and output follow the select bit.

A masked pending source tells raw status apart from enabled status. A line held high across an acknowledge separates edge capture from level capture. A rising edge placed in the same cycle as its acknowledge exposes which of the two takes priority.

A long random mix of source toggles, enable set and clear writes, select writes, acknowledges and reads is compared against a behavioural model on every clock. This catches errors in bit positions and address decoding.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int IDX_W  = 3;
    localparam int ADDR_W = IDX_W + 2;

    // register index = byte address bits [4:2]
    typedef enum logic [IDX_W-1:0] {
        REG_RAW   = 3'd0,
        REG_NSTAT = 3'd1,
        REG_FSTAT = 3'd2,
        REG_SEL   = 3'd3,
        REG_MASK  = 3'd4,
        REG_MSET  = 3'd5,
        REG_MCLR  = 3'd6,
        REG_EOI   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic sel_wr;
        logic set_wr;
        logic clr_wr;
        logic eoi_wr;
    } wr_strobe_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_steer_pkg::*;
(
    input  logic                bus_sel_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    output wr_strobe_t          wr_o,
    output logic                rd_en_o,
    output reg_idx_e            rd_idx_o
);

    logic     aligned;
    reg_idx_e idx;

    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign idx     = reg_idx_e'(bus_addr_i[ADDR_W-1:2]);

    always_comb begin
        wr_o = '0;
        if (bus_sel_i && bus_we_i && aligned) begin
            unique case (idx)
                REG_SEL:  wr_o.sel_wr = 1'b1;
                REG_MSET: wr_o.set_wr = 1'b1;
                REG_MCLR: wr_o.clr_wr = 1'b1;
                REG_EOI:  wr_o.eoi_wr = 1'b1;
                default:  wr_o = '0;
            endcase
        end
    end

    assign rd_en_o  = bus_sel_i && !bus_we_i && aligned;
    assign rd_idx_o = idx;

endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] src_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic rise;
        assign rise = src_i[g] && !src_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[g]  <= 1'b0;
                pend_o[g] <= 1'b0;
            end else begin
                src_q[g] <= src_i[g];
                if (rise)
                    pend_o[g] <= 1'b1;      // a new edge beats a same-cycle acknowledge
                else if (ack_i[g])
                    pend_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_strobe_t         wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] sel_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (wr_i.set_wr) begin
            mask_o <= mask_o | wdata_i;
        end else if (wr_i.clr_wr) begin
            mask_o <= mask_o & ~wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sel_o <= '0;
        else if (wr_i.sel_wr)
            sel_o <= wdata_i;
    end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] sel_i,
    input  logic               rd_en_i,
    input  reg_idx_e           rd_idx_i,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic               norm_o,
    output logic               fast_o
);

    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] norm_vec;
    logic [NUM_SRC-1:0] fast_vec;

    assign live     = pend_i & mask_i;
    assign norm_vec = live & ~sel_i;
    assign fast_vec = live & sel_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            norm_o <= 1'b0;
            fast_o <= 1'b0;
        end else begin
            norm_o <= |norm_vec;
            fast_o <= |fast_vec;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (rd_idx_i)
                REG_RAW:   rdata_o = pend_i;
                REG_NSTAT: rdata_o = norm_vec;
                REG_FSTAT: rdata_o = fast_vec;
                REG_SEL:   rdata_o = sel_i;
                REG_MASK:  rdata_o = mask_i;
                default:   rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               irq_norm_o,
    output logic               irq_fast_o
);

    wr_strobe_t         wr;
    logic               rd_en;
    reg_idx_e           rd_idx;
    logic [NUM_SRC-1:0] src_pend;
    logic [NUM_SRC-1:0] en_mask;
    logic [NUM_SRC-1:0] fast_sel;
    logic [NUM_SRC-1:0] ack_vec;

    irq_bus_decode u_dec (
        .bus_sel_i  (bus_sel_i),
        .bus_we_i   (bus_we_i),
        .bus_addr_i (bus_addr_i),
        .wr_o       (wr),
        .rd_en_o    (rd_en),
        .rd_idx_o   (rd_idx)
    );

    assign ack_vec = wr.eoi_wr ? bus_wdata_i : '0;

    irq_src_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (irq_src_i),
        .ack_i  (ack_vec),
        .pend_o (src_pend)
    );

    irq_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .wdata_i (bus_wdata_i),
        .mask_o  (en_mask),
        .sel_o   (fast_sel)
    );

    irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (src_pend),
        .mask_i   (en_mask),
        .sel_i    (fast_sel),
        .rd_en_i  (rd_en),
        .rd_idx_i (rd_idx),
        .rdata_o  (bus_rdata_o),
        .norm_o   (irq_norm_o),
        .fast_o   (irq_fast_o)
    );

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               bus_sel_i,
    input logic               bus_we_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [NUM_SRC-1:0] bus_wdata_i,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] sel,
    input logic               norm_o,
    input logic               fast_o
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] edge_w;
    logic               wr_set, wr_clr, wr_eoi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    assign edge_w = src_i & ~src_q;
    assign wr_set = bus_sel_i && bus_we_i && (bus_addr_i == 5'h14);
    assign wr_clr = bus_sel_i && bus_we_i && (bus_addr_i == 5'h18);
    assign wr_eoi = bus_sel_i && bus_we_i && (bus_addr_i == 5'h1C);

    a_r1_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(edge_w)) == $past(edge_w)));

    a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask & $past(bus_wdata_i)) == '0));

    a_r9_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eoi |=> ((pend & $past(bus_wdata_i) & ~$past(edge_w)) == '0));

    a_r10_norm_out: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (norm_o == $past(|(pend & mask & ~sel))));

    a_r10_fast_out: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fast_o == $past(|(pend & mask & sel))));

endmodule

bind irq_steer_ctrl irq_steer_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (irq_src_i),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pend        (src_pend),
    .mask        (en_mask),
    .sel         (fast_sel),
    .norm_o      (irq_norm_o),
    .fast_o      (irq_fast_o)
);

// File: tb/irq_steer_ctrl_tb.sv
module irq_steer_ctrl_tb;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         sel = 1'b0;
    logic         we = 1'b0;
    logic [4:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         norm, fast;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R11";

    always #5 clk = ~clk;

    irq_steer_ctrl #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_norm_o(norm), .irq_fast_o(fast)
    );

    // behavioural reference model, one source at a time
    bit [N-1:0] m_pend, m_mask, m_sel, m_prev;
    bit         m_norm, m_fast;

    function automatic bit wr_hit(input int off);
        return sel && we && (int'(addr) == off);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend <= '0; m_mask <= '0; m_sel <= '0; m_prev <= '0;
            m_norm <= 0;  m_fast <= 0;
        end else begin
            bit an, af;
            an = 0; af = 0;
            for (int i = 0; i < N; i++) begin
                if (m_pend[i] && m_mask[i]) begin
                    if (m_sel[i]) af = 1; else an = 1;
                end
                if (src[i] && !m_prev[i])           m_pend[i] <= 1'b1;
                else if (wr_hit('h1C) && wdata[i])  m_pend[i] <= 1'b0;
                if (wr_hit('h14) && wdata[i])       m_mask[i] <= 1'b1;
                if (wr_hit('h18) && wdata[i])       m_mask[i] <= 1'b0;
            end
            if (wr_hit('h0C)) m_sel <= wdata;
            m_prev <= src;
            m_norm <= an;
            m_fast <= af;
        end
    end

    function automatic bit [N-1:0] exp_read();
        if (!(sel && !we)) return '0;
        case (int'(addr))
            'h00: return m_pend;
            'h04: return m_pend & m_mask & ~m_sel;
            'h08: return m_pend & m_mask & m_sel;
            'h0C: return m_sel;
            'h10: return m_mask;
            default: return '0;   // write-only or misaligned (R8, R12)
        endcase
    endfunction

    function automatic string reg_tag();
        case (int'(addr))
            'h00: return "R7";
            'h04: return "R5";
            'h08: return "R6";
            'h0C: return "R4";
            'h10: return "R8";
            default: return (addr[1:0] != 0) ? "R12" : "R8";
        endcase
    endfunction

    // compare every clock, half a period after the edge
    always @(negedge clk) begin
        bit [N-1:0] er;
        er = exp_read();
        checks += 3;
        if (norm !== m_norm) begin
            errors++;
            $display("FAIL R10/%s normal output: got %0b expected %0b", cur_tag, norm, m_norm);
        end
        if (fast !== m_fast) begin
            errors++;
            $display("FAIL R10/%s fast output: got %0b expected %0b", cur_tag, fast, m_fast);
        end
        if (rdata !== er) begin
            errors++;
            $display("FAIL %s/%s read @%h: got %h expected %h", reg_tag(), cur_tag, addr, rdata, er);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #3; end
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        sel = 1; we = 1; addr = a; wdata = d;
        step();
        sel = 0; we = 0; wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a);
        sel = 1; we = 0; addr = a;
        step();
        sel = 0;
    endtask

    task automatic rd_all();
        for (int a = 0; a < 32; a += 4) rd(5'(a));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cur_tag = "R11";
        step(3);
        rst_n = 1;
        step();
        rd_all();                         // R11: everything reads zero

        cur_tag = "R2";
        wr('h14, 32'h0000_00FF);
        wr('h14, 32'h0000_0F00);
        rd('h10);

        cur_tag = "R3";
        wr('h18, 32'h0000_00F0);
        rd('h10);
        wr('h18, '1);
        rd('h10);

        cur_tag = "R4";
        wr('h0C, 32'hAAAA_AAAA);
        rd('h0C);

        cur_tag = "R8";
        wr('h10, '1);                     // read-only, ignored
        wr('h00, '1);
        rd('h10);
        rd('h14); rd('h18); rd('h1C);

        cur_tag = "R12";
        wr('h15, '1);                     // misaligned set, ignored
        rd('h10);
        rd('h11);

        cur_tag = "R5";
        wr('h14, '1);
        src[0] = 1; step(); src[0] = 0;   // source 0 -> normal (select 0)
        step(2);
        rd('h04); rd('h08); rd('h00);

        cur_tag = "R6";
        src[1] = 1; step(); src[1] = 0;   // source 1 -> fast (select 1)
        step(2);
        rd('h08); rd('h04);

        cur_tag = "R9";
        wr('h1C, 32'h3);
        step(2);
        rd('h00);

        cur_tag = "R1";
        src[3] = 1; step(3);              // held high
        wr('h1C, 32'h8);
        step(3);
        rd('h00);                         // no re-latch while level stays
        src[3] = 0; step();

        cur_tag = "R9";
        src[5] = 1; step(); src[5] = 0; step();
        src[5] = 1;                       // edge coincides with acknowledge
        wr('h1C, 32'h20);
        rd('h00);
        src[5] = 0;
        wr('h1C, 32'h20);
        rd('h00);

        cur_tag = "R7";
        wr('h18, 32'h100);
        src[8] = 1; step(); src[8] = 0; step(2);
        rd('h00); rd('h04);               // pending but masked

        cur_tag = "R10";
        wr('h14, 32'h100);
        step(2);
        wr('h1C, '1);
        step(2);

        cur_tag = "RAND";
        for (int k = 0; k < 600; k++) begin
            src = src ^ ($urandom() & $urandom() & $urandom());
            case ($urandom_range(0, 5))
                0: wr(5'($urandom_range(0, 7) * 4), $urandom());
                1: wr('h1C, $urandom());
                2: wr('h14, $urandom() & $urandom());
                3: wr('h18, $urandom());
                default: rd(5'($urandom_range(0, 7) * 4));
            endcase
        end
        src = '0;
        step(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule